// File: doc/BRIEF.md
# Flag-Setting Register ALU

This block is the arithmetic and logic unit behind the sixteen two-register operations of a compact instruction set. A 4-bit opcode picks the operation. The destination operand and the source operand are both 32 bits wide, and the current carry flag is the third input. The unit returns a 32-bit result and a write-enable for the destination register. It also returns new values for the negative (N), zero (Z), carry (C) and overflow (V) flags, with one update enable for each flag. Register file access is outside the block.

The operations fall into four classes, and each class has its own flag rule:

- Bitwise operations and the multiply change only N and Z.
- Shifts take their amount from the low byte of the source. They change N, Z and C, where C is the last bit shifted out.
- Add and subtract operations change all four flags. For subtracts, C means that no borrow occurred.
- The three compare-style operations change the flags without writing the destination.

The multiply is a single-cycle product. All outputs are registered, so a result appears one clock edge after its operands.

Top module: `flag_alu`

## Requirements
- R1: Opcode values map as: 0 AND, 1 EOR, 2 LSL, 3 LSR, 4 ASR, 5 ADC, 6 SBC, 7 ROR, 8 TST, 9 NEG, 10 CMP, 11 CMN, 12 ORR, 13 MUL, 14 BIC, 15 MVN. BIC gives dst AND NOT src, MVN gives NOT src, and MUL gives the low 32 bits of dst times src. Every operation other than TST, CMP and CMN raises destWe.
- R2: The flag vectors use bit 3 for N, bit 2 for Z, bit 1 for C and bit 0 for V. For every opcode, N equals bit 31 of the result and Z is set exactly when the result is zero. AND, EOR, ORR, BIC, MVN, TST and MUL set flagsUpd to 4'b1100.
- R3: ADC computes dst + src + C. SBC computes dst - src - (1 - C). NEG computes 0 - src, CMP computes dst - src and CMN computes dst + src. For all five, flagsUpd is 4'b1111 and C is the carry out of the whole computation; for the subtracts this means C is 1 when no borrow occurs. V is set when the operands, after inverting src for a subtract, share a sign that differs from the sign of the result.
- R4: TST, CMP and CMN drive destWe low. The result port still carries the value they computed.
- R5: Shifts (LSL, LSR, ASR, ROR) take their amount from src bits 7:0 and ignore the higher bits. They set flagsUpd to 4'b1110.
- R6: A shift amount of 0 returns dst unchanged and passes the carry input through as C.
- R7: LSL and LSR by 32 return 0, with C taken from bit 0 (LSL) or bit 31 (LSR). Amounts from 33 to 255 return 0 with C equal to 0.
- R8: ASR by 32 or more returns 32 copies of the dst sign bit, and C equals that sign bit.
- R9: ROR rotates right by the amount modulo 32. A nonzero amount that is a multiple of 32 leaves the value unchanged and sets C to bit 31.
- R10: All outputs are registered and change one rising clock edge after the inputs. While rst_n is low, every output is zero.
- R11: When C is not updated, flagsNew bit 1 repeats carryIn. When V is not updated, flagsNew bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opCode | input | 4 | Operation select |
| dstOp | input | 32 | Destination register operand |
| srcOp | input | 32 | Source register operand; the low byte is the shift amount |
| carryIn | input | 1 | Current carry flag |
| result | output | 32 | Operation result |
| destWe | output | 1 | Write-enable for the destination register |
| flagsNew | output | 4 | New N, Z, C, V values (bits 3..0) |
| flagsUpd | output | 4 | Per-flag update enables (bits 3..0) |

## Verification
Every output of this block (result, destWe, the new flags and the update enables) is due on the first rising edge after the operands and opcode are applied, and no output has a longer path. The bench changes inputs on the falling edge and samples the outputs on the next falling edge, which is exactly one register stage later. One directed check also samples just after a new input is driven, to confirm that the outputs have not yet moved before the clock edge. Expected values come from a behavioural model in the bench that handles each shift boundary and each borrow rule by explicit cases.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_LSL = 4'd2,  OP_LSR = 4'd3,
    OP_ASR = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_ROR = 4'd7,
    OP_TST = 4'd8,  OP_NEG = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MUL = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } aluOpE;

  typedef enum logic [1:0] {UNIT_LOGIC, UNIT_SHIFT, UNIT_ADDER, UNIT_MUL} unitE;
  typedef enum logic [2:0] {LG_AND, LG_EOR, LG_ORR, LG_BIC, LG_MVN} logicSelE;
  typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR} shiftSelE;
  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} carrySelE;

  // strobes from control to datapath
  typedef struct packed {
    unitE      unit;
    logicSelE  logicSel;
    shiftSelE  shiftSel;
    logic      invSrc;
    logic      zeroDst;
    carrySelE  carrySel;
    logic      wrDest;
    logic      updC;
    logic      updV;
  } aluCtrlS;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opCode,
  output aluCtrlS    ctrl
);

  always_comb begin
    ctrl = '{unit: UNIT_LOGIC, logicSel: LG_AND, shiftSel: SH_LSL, invSrc: 1'b0,
             zeroDst: 1'b0, carrySel: CIN_ZERO, wrDest: 1'b1, updC: 1'b0, updV: 1'b0};
    case (aluOpE'(opCode))
      OP_AND: ctrl.logicSel = LG_AND;
      OP_EOR: ctrl.logicSel = LG_EOR;
      OP_ORR: ctrl.logicSel = LG_ORR;
      OP_BIC: ctrl.logicSel = LG_BIC;
      OP_MVN: ctrl.logicSel = LG_MVN;
      OP_TST: begin ctrl.logicSel = LG_AND; ctrl.wrDest = 1'b0; end
      OP_MUL: ctrl.unit = UNIT_MUL;
      OP_LSL: begin ctrl.unit = UNIT_SHIFT; ctrl.shiftSel = SH_LSL; ctrl.updC = 1'b1; end
      OP_LSR: begin ctrl.unit = UNIT_SHIFT; ctrl.shiftSel = SH_LSR; ctrl.updC = 1'b1; end
      OP_ASR: begin ctrl.unit = UNIT_SHIFT; ctrl.shiftSel = SH_ASR; ctrl.updC = 1'b1; end
      OP_ROR: begin ctrl.unit = UNIT_SHIFT; ctrl.shiftSel = SH_ROR; ctrl.updC = 1'b1; end
      OP_ADC: begin
        ctrl.unit = UNIT_ADDER; ctrl.carrySel = CIN_FLAG;
        ctrl.updC = 1'b1; ctrl.updV = 1'b1;
      end
      OP_SBC: begin
        ctrl.unit = UNIT_ADDER; ctrl.invSrc = 1'b1; ctrl.carrySel = CIN_FLAG;
        ctrl.updC = 1'b1; ctrl.updV = 1'b1;
      end
      OP_NEG: begin
        ctrl.unit = UNIT_ADDER; ctrl.invSrc = 1'b1; ctrl.zeroDst = 1'b1;
        ctrl.carrySel = CIN_ONE; ctrl.updC = 1'b1; ctrl.updV = 1'b1;
      end
      OP_CMP: begin
        ctrl.unit = UNIT_ADDER; ctrl.invSrc = 1'b1; ctrl.carrySel = CIN_ONE;
        ctrl.wrDest = 1'b0; ctrl.updC = 1'b1; ctrl.updV = 1'b1;
      end
      OP_CMN: begin
        ctrl.unit = UNIT_ADDER; ctrl.carrySel = CIN_ZERO;
        ctrl.wrDest = 1'b0; ctrl.updC = 1'b1; ctrl.updV = 1'b1;
      end
      default: ;
    endcase
  end

  // R4: compare-style operations never request a destination write
  a_r4_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == OP_TST || opCode == OP_CMP || opCode == OP_CMN) |-> !ctrl.wrDest);

  // R5: every shift asks for carry but never overflow
  a_r5_shift_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode inside {OP_LSL, OP_LSR, OP_ASR, OP_ROR}) |-> (ctrl.updC && !ctrl.updV));

endmodule

// File: rtl/flag_alu_shifter.sv
module flag_alu_shifter
  import flag_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = 8
) (
  input  shiftSelE            shiftSel,
  input  logic [DATA_W-1:0]   val,
  input  logic [SHAMT_W-1:0]  amt,
  input  logic                cIn,
  output logic [DATA_W-1:0]   res,
  output logic                cOut
);

  localparam int unsigned ROT_W = $clog2(DATA_W);

  logic [DATA_W:0]     wideLeft;
  logic [DATA_W:0]     wideRight;
  logic [DATA_W:0]     wideArith;
  logic [2*DATA_W-1:0] rotPair;
  logic [ROT_W-1:0]    rotAmt;

  // the extra bit catches the last bit shifted out; large amounts fall to zero
  always_comb begin
    wideLeft  = {1'b0, val} << amt;
    wideRight = {val, 1'b0} >> amt;
    wideArith = $signed({val, 1'b0}) >>> amt;
    rotAmt    = amt[ROT_W-1:0];
    rotPair   = {val, val} >> rotAmt;
  end

  always_comb begin
    res  = val;
    cOut = cIn;
    if (amt != '0) begin
      case (shiftSel)
        SH_LSL: begin res = wideLeft[DATA_W-1:0];  cOut = wideLeft[DATA_W]; end
        SH_LSR: begin res = wideRight[DATA_W:1];   cOut = wideRight[0];     end
        SH_ASR: begin res = wideArith[DATA_W:1];   cOut = wideArith[0];     end
        default: begin
          res  = rotPair[DATA_W-1:0];
          cOut = rotPair[DATA_W-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/flag_alu_datapath.sv
module flag_alu_datapath
  import flag_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  aluCtrlS           ctrl,
  input  logic [DATA_W-1:0] aOp,
  input  logic [DATA_W-1:0] bOp,
  input  logic              cIn,
  output logic [DATA_W-1:0] result,
  output logic              destWe,
  output logic [3:0]        flagsNew,
  output logic [3:0]        flagsUpd
);

  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] logicRes, shiftRes, mulRes, addA, addB, nextRes;
  logic [DATA_W:0]   addSum;
  logic              addCin, addC, addV, shiftC, nextC, nextV;

  flag_alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .shiftSel (ctrl.shiftSel),
    .val      (aOp),
    .amt      (bOp[SHAMT_W-1:0]),
    .cIn      (cIn),
    .res      (shiftRes),
    .cOut     (shiftC)
  );

  always_comb begin
    case (ctrl.logicSel)
      LG_EOR:  logicRes = aOp ^ bOp;
      LG_ORR:  logicRes = aOp | bOp;
      LG_BIC:  logicRes = aOp & ~bOp;
      LG_MVN:  logicRes = ~bOp;
      default: logicRes = aOp & bOp;
    endcase
  end

  assign mulRes = aOp * bOp;

  // single adder: subtract = add inverted source with carry-in
  always_comb begin
    addA = ctrl.zeroDst ? '0 : aOp;
    addB = ctrl.invSrc ? ~bOp : bOp;
    case (ctrl.carrySel)
      CIN_ONE:  addCin = 1'b1;
      CIN_FLAG: addCin = cIn;
      default:  addCin = 1'b0;
    endcase
    addSum = {1'b0, addA} + {1'b0, addB} + {{DATA_W{1'b0}}, addCin};
    addC   = addSum[DATA_W];
    addV   = (addA[MSB] == addB[MSB]) && (addSum[MSB] != addA[MSB]);
  end

  always_comb begin
    case (ctrl.unit)
      UNIT_SHIFT: nextRes = shiftRes;
      UNIT_ADDER: nextRes = addSum[DATA_W-1:0];
      UNIT_MUL:   nextRes = mulRes;
      default:    nextRes = logicRes;
    endcase
    nextC = ctrl.updC ? ((ctrl.unit == UNIT_SHIFT) ? shiftC : addC) : cIn;
    nextV = ctrl.updV ? addV : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      destWe   <= 1'b0;
      flagsNew <= '0;
      flagsUpd <= '0;
    end else begin
      result   <= nextRes;
      destWe   <= ctrl.wrDest;
      flagsNew <= {nextRes[MSB], (nextRes == '0), nextC, nextV};
      flagsUpd <= {1'b1, 1'b1, ctrl.updC, ctrl.updV};
    end
  end

  // R3: a plain compare reports carry exactly when dst >= src (no borrow)
  a_r3_cmp_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.unit == UNIT_ADDER && ctrl.invSrc && !ctrl.zeroDst && ctrl.carrySel == CIN_ONE)
    |=> (flagsNew[FLAG_C] == ($past(aOp) >= $past(bOp))));

  // R6: a zero shift amount passes value and carry through
  a_r6_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.unit == UNIT_SHIFT && bOp[SHAMT_W-1:0] == '0)
    |=> (result == $past(aOp) && flagsNew[FLAG_C] == $past(cIn)));

  // R8: large arithmetic shifts fill with the sign
  a_r8_asr_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.unit == UNIT_SHIFT && ctrl.shiftSel == SH_ASR && bOp[SHAMT_W-1:0] >= DATA_W)
    |=> ((result == '0 || result == '1) && result[MSB] == $past(aOp[MSB])
         && flagsNew[FLAG_C] == $past(aOp[MSB])));

  // R11: carry not updated means carry-in repeated and no update flagged
  a_r11_keep_carry: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.updC |=> (flagsNew[FLAG_C] == $past(cIn) && !flagsUpd[FLAG_C]));

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] dstOp,
  input  logic [DATA_W-1:0] srcOp,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              destWe,
  output logic [3:0]        flagsNew,
  output logic [3:0]        flagsUpd
);

  aluCtrlS ctrl;

  flag_alu_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  flag_alu_datapath #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .aOp      (dstOp),
    .bOp      (srcOp),
    .cIn      (carryIn),
    .result   (result),
    .destWe   (destWe),
    .flagsNew (flagsNew),
    .flagsUpd (flagsUpd)
  );

endmodule

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;

  localparam real CLK_PERIOD = 5.0;
  localparam int  NUM_VEC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] dstOp = '0;
  logic [31:0] srcOp = '0;
  logic        carryIn = 1'b0;
  logic [31:0] result;
  logic        destWe;
  logic [3:0]  flagsNew;
  logic [3:0]  flagsUpd;

  int checkCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rst_n(rst_n), .opCode(opCode), .dstOp(dstOp), .srcOp(srcOp),
    .carryIn(carryIn), .result(result), .destWe(destWe),
    .flagsNew(flagsNew), .flagsUpd(flagsUpd)
  );

  // stimulus table: {op, dst, src, carry}
  localparam logic [68:0] VEC [NUM_VEC] = '{
    {4'd0,  32'hF0F0_1234, 32'h0FF0_FF00, 1'b1},
    {4'd1,  32'hAAAA_5555, 32'hAAAA_5555, 1'b0},
    {4'd2,  32'h8000_0001, 32'h0000_0001, 1'b0},
    {4'd3,  32'h0000_0003, 32'h0000_0001, 1'b0},
    {4'd4,  32'h8000_0000, 32'h0000_001F, 1'b0},
    {4'd5,  32'h7FFF_FFFF, 32'h0000_0000, 1'b1},
    {4'd6,  32'h0000_0005, 32'h0000_0003, 1'b1},
    {4'd7,  32'h0000_0001, 32'h0000_0001, 1'b0},
    {4'd8,  32'h0000_00F0, 32'h0000_000F, 1'b1},
    {4'd9,  32'h1234_5678, 32'h0000_0001, 1'b0},
    {4'd10, 32'h0000_0001, 32'h0000_0002, 1'b0},
    {4'd11, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0},
    {4'd12, 32'h0000_0000, 32'h0000_0000, 1'b1},
    {4'd13, 32'h0001_0000, 32'h0001_0003, 1'b0},
    {4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b1},
    {4'd15, 32'h0000_0000, 32'h0000_0000, 1'b0}
  };

  // behavioural model: returns {result, we, flags[3:0], upd[3:0]}
  function automatic logic [40:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic cin);
    logic [31:0] r;
    logic we, c, v;
    logic [3:0] upd;
    logic [63:0] ua, ub;
    int n, m;
    r = '0; we = 1'b1; c = cin; v = 1'b0; upd = 4'b1100;
    ua = {32'd0, a}; ub = {32'd0, b};
    n = int'(b[7:0]);
    case (op)
      4'd0:  r = a & b;
      4'd1:  r = a ^ b;
      4'd12: r = a | b;
      4'd14: r = a & ~b;
      4'd15: r = ~b;
      4'd13: r = a * b;
      4'd8:  begin r = a & b; we = 1'b0; end
      4'd5, 4'd11: begin
        logic cc;
        cc = (op == 4'd5) ? cin : 1'b0;
        r = a + b + {31'd0, cc};
        c = (ua + ub + {63'd0, cc}) > 64'hFFFF_FFFF;
        v = (a[31] == b[31]) && (r[31] != a[31]);
        upd = 4'b1111; we = (op == 4'd5);
      end
      4'd6, 4'd10: begin
        logic bw;
        bw = (op == 4'd6) ? !cin : 1'b0;
        r = a - b - {31'd0, bw};
        c = ua >= (ub + {63'd0, bw});
        v = (a[31] != b[31]) && (r[31] != a[31]);
        upd = 4'b1111; we = (op == 4'd6);
      end
      4'd9: begin
        r = 32'd0 - b; c = (b == 32'd0); v = (b == 32'h8000_0000);
        upd = 4'b1111;
      end
      default: begin
        upd = 4'b1110;
        if (n == 0) begin
          r = a; c = cin;
        end else if (op == 4'd2) begin
          if (n < 32) begin r = a << n; c = a[32 - n]; end
          else if (n == 32) begin r = '0; c = a[0]; end
          else begin r = '0; c = 1'b0; end
        end else if (op == 4'd3) begin
          if (n < 32) begin r = a >> n; c = a[n - 1]; end
          else if (n == 32) begin r = '0; c = a[31]; end
          else begin r = '0; c = 1'b0; end
        end else if (op == 4'd4) begin
          if (n < 32) begin r = $unsigned($signed(a) >>> n); c = a[n - 1]; end
          else begin r = {32{a[31]}}; c = a[31]; end
        end else begin
          m = n % 32;
          if (m == 0) begin r = a; c = a[31]; end
          else begin r = (a >> m) | (a << (32 - m)); c = a[m - 1]; end
        end
      end
    endcase
    return {r, we, r[31], (r == 32'd0), c, v, upd};
  endfunction

  function automatic string tagFor(input logic [3:0] op);
    case (op)
      4'd2, 4'd3: return "R1,R5,R7";
      4'd4:       return "R1,R5,R8";
      4'd7:       return "R1,R5,R9";
      4'd5, 4'd6, 4'd9, 4'd10, 4'd11: return "R1,R3,R4";
      default:    return "R1,R2,R4,R11";
    endcase
  endfunction

  function automatic logic [40:0] got();
    return {result, destWe, flagsNew, flagsUpd};
  endfunction

  task automatic check(input string tag, input logic [40:0] act, input logic [40:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h (res,we,flags,upd)", tag, act, exp);
    end
  endtask

  // drive on falling edge, sample on the next falling edge (one register stage)
  task automatic applyOp(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic cin);
    @(negedge clk);
    opCode = op; dstOp = a; srcOp = b; carryIn = cin;
    @(negedge clk);
  endtask

  task automatic runModel(input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic cin);
    applyOp(op, a, b, cin);
    check(tagFor(op), got(), model(op, a, b, cin));
  endtask

  function automatic logic [31:0] pickOperand(input int sel);
    case (sel % 6)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [31:0] pickAmount(input int sel);
    logic [31:0] hi;
    hi = $urandom & 32'hFFFF_FF00;
    case (sel % 7)
      0: return hi | 32'd0;
      1: return hi | 32'd31;
      2: return hi | 32'd32;
      3: return hi | 32'd33;
      4: return hi | 32'd255;
      5: return hi | 32'd64;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    checkCount++;
    failCount++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    // R10: outputs held at zero while reset is low, even with live inputs
    opCode = 4'd15; dstOp = 32'h1234_5678; srcOp = 32'h0; carryIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset", got(), 41'd0);
    rst_n = 1'b1;

    // R10: one-edge latency; output unchanged right after a drive
    applyOp(4'd0, 32'hFFFF_0000, 32'h00FF_FF00, 1'b0);
    check("R10 latency", got(), model(4'd0, 32'hFFFF_0000, 32'h00FF_FF00, 1'b0));
    opCode = 4'd15; srcOp = 32'h0;
    #1;
    check("R10 before edge", got(), model(4'd0, 32'hFFFF_0000, 32'h00FF_FF00, 1'b0));
    @(negedge clk);
    check("R10 after edge", got(), {32'hFFFF_FFFF, 1'b1, 4'b1000, 4'b1100});

    // table walk
    for (int i = 0; i < NUM_VEC; i++) begin
      runModel(VEC[i][68:65], VEC[i][64:33], VEC[i][32:1], VEC[i][0]);
    end

    // directed corners with literal expectations
    applyOp(4'd2, 32'h0000_0001, 32'd32, 1'b0);
    check("R7 LSL by 32", got(), {32'h0, 1'b1, 4'b0110, 4'b1110});
    applyOp(4'd3, 32'hFFFF_FFFF, 32'd33, 1'b1);
    check("R7 LSR by 33", got(), {32'h0, 1'b1, 4'b0100, 4'b1110});
    applyOp(4'd3, 32'h8000_0000, 32'd32, 1'b0);
    check("R7 LSR by 32", got(), {32'h0, 1'b1, 4'b0110, 4'b1110});
    applyOp(4'd4, 32'h8000_0000, 32'd255, 1'b0);
    check("R8 ASR by 255", got(), {32'hFFFF_FFFF, 1'b1, 4'b1010, 4'b1110});
    applyOp(4'd7, 32'h8000_0001, 32'd64, 1'b0);
    check("R9 ROR by 64", got(), {32'h8000_0001, 1'b1, 4'b1010, 4'b1110});
    applyOp(4'd7, 32'h0000_0003, 32'd33, 1'b0);
    check("R9 ROR by 33", got(), {32'h8000_0001, 1'b1, 4'b1010, 4'b1110});
    applyOp(4'd2, 32'h8765_4321, 32'hFFFF_FF00, 1'b1);
    check("R5 R6 high bits ignored, zero amount", got(), {32'h8765_4321, 1'b1, 4'b1010, 4'b1110});
    applyOp(4'd6, 32'h0, 32'h0, 1'b0);
    check("R3 SBC borrow", got(), {32'hFFFF_FFFF, 1'b1, 4'b1000, 4'b1111});
    applyOp(4'd5, 32'hFFFF_FFFF, 32'h0, 1'b1);
    check("R3 ADC carry", got(), {32'h0, 1'b1, 4'b0110, 4'b1111});
    applyOp(4'd10, 32'h8000_0000, 32'h1, 1'b0);
    check("R3 R4 CMP overflow", got(), {32'h7FFF_FFFF, 1'b0, 4'b0011, 4'b1111});
    applyOp(4'd9, 32'hDEAD_BEEF, 32'h8000_0000, 1'b0);
    check("R3 NEG min", got(), {32'h8000_0000, 1'b1, 4'b1001, 4'b1111});
    applyOp(4'd9, 32'hDEAD_BEEF, 32'h0, 1'b0);
    check("R3 NEG zero", got(), {32'h0, 1'b1, 4'b0110, 4'b1111});
    applyOp(4'd8, 32'hF000_0000, 32'h8000_0000, 1'b1);
    check("R4 R11 TST", got(), {32'h8000_0000, 1'b0, 4'b1010, 4'b1100});
    applyOp(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    check("R1 R2 MUL low word", got(), {32'h1, 1'b1, 4'b0000, 4'b1100});

    // random and corner operands for every opcode
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 42; k++) begin
        logic [31:0] a, b;
        a = pickOperand(k);
        b = (op inside {2, 3, 4, 7}) ? pickAmount(k) : pickOperand(k / 6 + k);
        runModel(4'(op), a, b, 1'(k % 2));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule